// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Sequence Integrity

This block switches bytes between several byte-wide TDM streams whose frames each hold 32 time slots. One clock cycle carries one time slot on every stream at once. Every incoming byte is stored in a frame-banked data memory, and a connection memory tells each output stream, slot by slot, which input stream and slot to send. A processor programs connections through a two-step port: it first writes the target address, then writes the entry.

Each connection chooses one of two delay modes. In the shortest-delay mode the byte leaves as soon as its output slot comes round. In the sequence-integrity mode every byte of a connection leaves exactly two frame boundaries after it arrived, so a group of slots that belongs together keeps its order. A connection can also feed its output byte back into the input of the stream with the same index, and a global disable input turns all output enables off at once.

Top module: `tsi_switch`

## Requirements
- R1: A frame has 32 slots. The first clock edge after reset releases handles slot 0, and each later edge handles the next slot, wrapping from 31 to 0. The byte for output slot s appears on `dout` in the cycle after the edge that handles slot s.
- R2: In the shortest-delay mode, with output slot s later than source slot i, the output carries the byte that came in at slot i of the same frame, a delay of s-i slots.
- R3: In the shortest-delay mode, with output slot s equal to or earlier than source slot i, the output carries the byte from slot i of the previous frame, a delay of 32-(i-s) slots.
- R4: With the sequence-integrity bit set, the output carries the byte from slot i two frames back, a delay of (32-i)+32+s slots. That delay lies between 33 and 95 slots. The data memory holds three frame banks, which rotate at the end of every slot 31.
- R5: An output slot whose entry has its valid bit clear drives its enable bit low and a data byte of 0xFF.
- R6: When an entry for output stream o has both its valid bit and its loopback bit set, the byte it sends is also written as input stream o's byte for that slot, in place of the external byte. Later reads of that stream and slot return the fed-back byte.
- R7: While `outDisable` is high, every bit of `doutOe` is low in the same cycle. The data path keeps running.
- R8: A pulse on `cfgAddrWr` latches the target address from `cfgWdata`: bits [4:0] give the output slot and bits [6:5] the output stream. A later pulse on `cfgDataWr` commits `cfgWdata` as that entry. Bits [4:0] give the source slot, [6:5] the source stream, bit 7 valid, bit 8 sequence integrity and bit 9 loopback. The slot handled in the cycle of the commit still uses the old entry.
- R9: Reset clears every connection entry to invalid, drives `doutOe` to zero and sets `dout` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Input bytes, stream n in bits [8n+7:8n] |
| outDisable | input | 1 | Forces all output enables low |
| cfgAddrWr | input | 1 | Latch the connection address from cfgWdata |
| cfgDataWr | input | 1 | Commit cfgWdata to the addressed entry |
| cfgWdata | input | 10 | Processor write data (address or entry) |
| dout | output | 32 | Output bytes, stream n in bits [8n+7:8n] |
| doutOe | output | 4 | Per-stream output enable, low means high impedance |

## Verification
The interesting collision is a connection-memory commit that lands in the same cycle as the read of that same entry. The processor rewrites the entry for output stream 0, slot 5 with its commit pulse placed exactly on slot 5. The bench expects that slot to carry the byte chosen by the old mapping, and slot 5 of the following frames to carry the byte chosen by the new one. A second overlap, a loopback write and an external input byte aimed at the same data-memory cell in one cycle, is judged by reading that cell back through another connection and expecting the fed-back byte.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int STREAMS  = 4;
  parameter int SLOTS    = 32;
  parameter int BYTE_W   = 8;
  parameter int BANKS    = 3;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int STREAM_W = $clog2(STREAMS);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int ADDR_W   = STREAM_W + SLOT_W;

  // connection entry, MSB first: loop, seqInt, valid, srcStream, srcSlot
  typedef struct packed {
    logic                loop;
    logic                seqInt;
    logic                valid;
    logic [STREAM_W-1:0] srcStream;
    logic [SLOT_W-1:0]   srcSlot;
  } conn_entry_t;

  localparam int CFG_W = $bits(conn_entry_t);

  // strobes from control to datapath for the current slot
  typedef struct packed {
    logic [SLOT_W-1:0]                 slot;
    logic [BANK_W-1:0]                 wrBank;
    logic [STREAMS-1:0]                rdValid;
    logic [STREAMS-1:0]                rdLoop;
    logic [STREAMS-1:0][BANK_W-1:0]    rdBank;
    logic [STREAMS-1:0][STREAM_W-1:0]  rdStream;
    logic [STREAMS-1:0][SLOT_W-1:0]    rdSlot;
  } dp_ctrl_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgAddrWr,
  input  logic             cfgDataWr,
  input  logic [CFG_W-1:0] cfgWdata,
  output dp_ctrl_t         strobes
);
  logic [SLOT_W-1:0] slotCnt;
  logic [BANK_W-1:0] bankCur;
  logic [BANK_W-1:0] bankPrev;
  logic [BANK_W-1:0] bankOlder;
  logic [ADDR_W-1:0] addrReg;
  conn_entry_t       connMem [STREAMS][SLOTS];

  // slot counter and frame bank rotation
  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      bankCur <= '0;
    end else begin
      if (slotCnt == SLOT_W'(SLOTS-1)) begin
        slotCnt <= '0;
        bankCur <= (bankCur == BANK_W'(BANKS-1)) ? '0 : bankCur + 1'b1;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  assign bankPrev  = (bankCur == '0) ? BANK_W'(BANKS-1) : bankCur - 1'b1;
  assign bankOlder = (bankCur == BANK_W'(BANKS-1)) ? '0 : bankCur + 1'b1;

  // processor access: address register, then data register commits
  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      for (int o = 0; o < STREAMS; o++)
        for (int s = 0; s < SLOTS; s++)
          connMem[o][s] <= '0;
    end else begin
      if (cfgAddrWr)
        addrReg <= cfgWdata[ADDR_W-1:0];
      if (cfgDataWr)
        connMem[addrReg[ADDR_W-1:SLOT_W]][addrReg[SLOT_W-1:0]] <= conn_entry_t'(cfgWdata);
    end
  end

  assign strobes.slot   = slotCnt;
  assign strobes.wrBank = bankCur;

  for (genvar o = 0; o < STREAMS; o++) begin : g_rd
    conn_entry_t ent;
    assign ent = connMem[o][slotCnt];
    assign strobes.rdValid[o]  = ent.valid;
    assign strobes.rdLoop[o]   = ent.loop;
    assign strobes.rdStream[o] = ent.srcStream;
    assign strobes.rdSlot[o]   = ent.srcSlot;
    assign strobes.rdBank[o]   = ent.seqInt              ? bankOlder :
                                 (slotCnt > ent.srcSlot) ? bankCur   : bankPrev;
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  dp_ctrl_t                    ctrl,
  input  logic [STREAMS*BYTE_W-1:0]   din,
  input  logic                        outDisable,
  output logic [STREAMS*BYTE_W-1:0]   dout,
  output logic [STREAMS-1:0]          doutOe
);
  logic [BYTE_W-1:0]              dataMem [BANKS][STREAMS][SLOTS];
  logic [STREAMS-1:0][BYTE_W-1:0] readByte;
  logic [STREAMS-1:0][BYTE_W-1:0] wrByte;
  logic [STREAMS-1:0][BYTE_W-1:0] doutReg;
  logic [STREAMS-1:0]             oeReg;

  for (genvar o = 0; o < STREAMS; o++) begin : g_lane
    assign readByte[o] = dataMem[ctrl.rdBank[o]][ctrl.rdStream[o]][ctrl.rdSlot[o]];
    // loopback replaces the external byte of the paired stream
    assign wrByte[o]   = (ctrl.rdValid[o] && ctrl.rdLoop[o]) ? readByte[o]
                                                             : din[o*BYTE_W +: BYTE_W];
    assign dout[o*BYTE_W +: BYTE_W] = doutReg[o];
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < STREAMS; s++)
      dataMem[ctrl.wrBank][s][ctrl.slot] <= wrByte[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doutReg <= '1;
      oeReg   <= '0;
    end else begin
      for (int o = 0; o < STREAMS; o++) begin
        doutReg[o] <= ctrl.rdValid[o] ? readByte[o] : '1;
        oeReg[o]   <= ctrl.rdValid[o];
      end
    end
  end

  assign doutOe = oeReg & ~{STREAMS{outDisable}};
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [STREAMS*BYTE_W-1:0] din,
  input  logic                      outDisable,
  input  logic                      cfgAddrWr,
  input  logic                      cfgDataWr,
  input  logic [CFG_W-1:0]          cfgWdata,
  output logic [STREAMS*BYTE_W-1:0] dout,
  output logic [STREAMS-1:0]        doutOe
);
  dp_ctrl_t          strobes;
  logic [SLOT_W-1:0] slotIdx;
  logic [BANK_W-1:0] curBank;

  tsi_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgAddrWr (cfgAddrWr),
    .cfgDataWr (cfgDataWr),
    .cfgWdata  (cfgWdata),
    .strobes   (strobes)
  );

  tsi_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (strobes),
    .din        (din),
    .outDisable (outDisable),
    .dout       (dout),
    .doutOe     (doutOe)
  );

  assign slotIdx = strobes.slot;
  assign curBank = strobes.wrBank;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic                      outDisable,
  input logic [STREAMS*BYTE_W-1:0] dout,
  input logic [STREAMS-1:0]        doutOe,
  input logic [SLOT_W-1:0]         slotIdx,
  input logic [BANK_W-1:0]         curBank
);
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (slotIdx == SLOT_W'(SLOTS-1)) |=> (slotIdx == '0));

  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    (slotIdx != SLOT_W'(SLOTS-1)) |=> (slotIdx == $past(slotIdx) + 1'b1));

  p_bank_rotate_r4: assert property (@(posedge clk) disable iff (rst)
    (slotIdx == SLOT_W'(SLOTS-1)) |=> (curBank != $past(curBank)));

  p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (slotIdx != SLOT_W'(SLOTS-1)) |=> $stable(curBank));

  p_disable_hiz_r7: assert property (@(posedge clk) disable iff (rst)
    outDisable |-> (doutOe == '0));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (doutOe == '0));

  for (genvar o = 0; o < STREAMS; o++) begin : g_idle
    p_idle_ones_r5: assert property (@(posedge clk) disable iff (rst)
      (!outDisable && !doutOe[o]) |-> (dout[o*BYTE_W +: BYTE_W] == '1));
  end
endmodule

bind tsi_switch tsi_switch_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .outDisable (outDisable),
  .dout       (dout),
  .doutOe     (doutOe),
  .slotIdx    (slotIdx),
  .curBank    (curBank)
);

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
  localparam int NS = 4;
  localparam int NT = 32;
  localparam time CLK_P = 8ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   din = '0;
  logic          outDisable = 1'b0;
  logic          cfgAddrWr = 1'b0;
  logic          cfgDataWr = 1'b0;
  logic [9:0]    cfgWdata = '0;
  logic [31:0]   dout;
  logic [3:0]    doutOe;

  always #(CLK_P/2) clk = ~clk;

  tsi_switch dut_i (
    .clk(clk), .rst(rst), .din(din), .outDisable(outDisable),
    .cfgAddrWr(cfgAddrWr), .cfgDataWr(cfgDataWr), .cfgWdata(cfgWdata),
    .dout(dout), .doutOe(doutOe)
  );

  typedef struct {
    int         o;
    logic [7:0] d;
    bit         oe;
    bit         chkData;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  hist[int];
  bit          looped[int];
  int          tv[NS][NT], ts[NS][NT], tsl[NS][NT], tsi[NS][NT], tlp[NS][NT];
  int          addrTb = 0;
  int          k = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  string       phaseTag = "";

  function automatic logic [7:0] pat(int i, int c);
    return 8'((c * 37 + i * 91 + 13) & 255);
  endfunction

  // driver: drive one slot, push expectations; monitor: pop and compare
  task automatic step(input bit aw = 0, input bit dw = 0,
                      input logic [9:0] w = '0, input bit dis = 0);
    int f = k / NT;
    int s = k % NT;
    exp_t e;
    logic [7:0] outExp[NS];
    bit known[NS];
    for (int i = 0; i < NS; i++) din[i*8 +: 8] = pat(i, k);
    cfgAddrWr = aw; cfgDataWr = dw; cfgWdata = w; outDisable = dis;
    for (int o = 0; o < NS; o++) begin
      e.o = o; e.oe = 1'b0; e.d = 8'hFF; e.chkData = 1'b1; known[o] = 1'b0;
      outExp[o] = 8'hFF;
      if (tv[o][s] == 0) begin
        e.tag = "R5";
      end else begin
        int srcK, key;
        if (tsi[o][s] != 0) begin srcK = (f - 2) * NT + tsl[o][s]; e.tag = "R4"; end
        else if (s > tsl[o][s]) begin srcK = f * NT + tsl[o][s]; e.tag = "R2"; end
        else begin srcK = (f - 1) * NT + tsl[o][s]; e.tag = "R3"; end
        key = srcK * NS + ts[o][s];
        e.oe = 1'b1;
        if (srcK >= 0 && hist.exists(key)) begin
          known[o] = 1'b1; outExp[o] = hist[key]; e.d = hist[key];
          if (looped.exists(key)) e.tag = "R6";
        end else begin
          e.chkData = 1'b0;
        end
      end
      if (dis) begin e.oe = 1'b0; e.chkData = 1'b0; e.tag = "R7"; end
      if (phaseTag != "") e.tag = phaseTag;
      sb.push_back(e);
    end
    for (int i = 0; i < NS; i++) begin
      if (tv[i][s] != 0 && tlp[i][s] != 0) begin
        if (known[i]) begin hist[k*NS+i] = outExp[i]; looped[k*NS+i] = 1'b1; end
      end else begin
        hist[k*NS+i] = pat(i, k);
      end
    end
    if (dw) begin
      int ao = addrTb / NT, as = addrTb % NT;
      ts[ao][as] = int'(w[6:5]); tsl[ao][as] = int'(w[4:0]);
      tv[ao][as] = int'(w[7]); tsi[ao][as] = int'(w[8]); tlp[ao][as] = int'(w[9]);
    end
    if (aw) addrTb = int'(w[6:0]);
    k++;
    @(negedge clk);
    for (int o = 0; o < NS; o++) begin
      exp_t it = sb.pop_front();
      checks++;
      if (doutOe[it.o] !== it.oe) begin
        errors++;
        $display("FAIL %s cycle %0d stream %0d oe: actual %b expected %b",
                 it.tag, k-1, it.o, doutOe[it.o], it.oe);
      end
      if (it.chkData) begin
        checks++;
        if (dout[it.o*8 +: 8] !== it.d) begin
          errors++;
          $display("FAIL %s cycle %0d stream %0d data: actual %h expected %h",
                   it.tag, k-1, it.o, dout[it.o*8 +: 8], it.d);
        end
      end
    end
  endtask

  task automatic prog(input int o, input int s, input int src, input int sl,
                      input bit si, input bit lp);
    step(1'b1, 1'b0, 10'((o << 5) | s));
    step(1'b0, 1'b1, 10'((int'(lp) << 9) | (int'(si) << 8) | (1 << 7) | (src << 5) | sl));
  endtask

  task automatic run(input int n, input bit dis = 0);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, dis);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < NS; o++)
      for (int s = 0; s < NT; s++) begin
        tv[o][s] = 0; ts[o][s] = 0; tsl[o][s] = 0; tsi[o][s] = 0; tlp[o][s] = 0;
      end
    repeat (4) @(negedge clk);
    // R9: reset state
    for (int o = 0; o < NS; o++) begin
      checks += 2;
      if (doutOe[o] !== 1'b0) begin
        errors++; $display("FAIL R9 reset oe stream %0d: actual %b expected 0", o, doutOe[o]);
      end
      if (dout[o*8 +: 8] !== 8'hFF) begin
        errors++; $display("FAIL R9 reset data stream %0d: actual %h expected ff", o, dout[o*8 +: 8]);
      end
    end
    rst = 1'b0;
    phaseTag = "R1";
    prog(0, 5, 1, 10, 1'b0, 1'b0);   // R3: output before source, next frame
    prog(1, 20, 0, 3, 1'b0, 1'b0);   // R2: same frame
    prog(2, 0, 3, 31, 1'b1, 1'b0);   // R4: minimum constant delay 33
    prog(3, 31, 2, 0, 1'b1, 1'b0);   // R4: maximum constant delay 95
    prog(2, 10, 2, 10, 1'b0, 1'b0);  // R3: equal slot, delay 32
    prog(1, 1, 2, 7, 1'b0, 1'b1);    // R6: loopback into stream 1 slot 1
    prog(0, 2, 1, 1, 1'b0, 1'b0);    // R6: read the fed-back byte
    run(NT - (k % NT));
    phaseTag = "";
    run(6 * NT);
    run(40, 1'b1);                    // R7: global disable
    run(NT - (k % NT) + 4);
    step(1'b1, 1'b0, 10'((0 << 5) | 5));
    phaseTag = "R8";                  // R8: commit lands on slot 5 itself
    step(1'b0, 1'b1, 10'((1 << 8) | (1 << 7) | (3 << 5) | 20));
    phaseTag = "";
    run(3 * NT);
    prog(3, 31, 0, 0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 10'((3 << 5) | 31));
    step(1'b0, 1'b1, 10'(0));         // R5: entry cleared to invalid
    run(2 * NT);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule